// File: doc/BRIEF.md
# CPU-versus-Transfer-Engine Priority Gate

This block sits between a set of transfer activation request lines and a data-transfer engine. Each request pulse is latched into a sticky per-line pending flag. The flag is offered to the engine until the engine acknowledges that line. When priority gating is switched on and the CPU's priority level is strictly higher than the level assigned to the transfer engine, every pending activation is held back. Held activations are kept, not dropped, and are offered again as soon as the CPU stops outranking the engine.

A single control register holds the gating enable, an auto-assign enable, the CPU level field and the engine level field. With auto-assign on, the CPU level follows the CPU's interrupt mask without software action. The mapping depends on the interrupt control mode. In the single-mask-bit mode, the mask bit lands in the top bit of the level. In the three-bit mode, the mask is copied as is. With auto-assign off, only software writes change the CPU level.

Top module: `xfer_prio_gate`

## Requirements
- R1: After reset, every register field reads 0, no line is pending and `req_out` is all zeros.
- R2: The register layout is bit 0 = gating enable, bit 1 = auto-assign enable, bits 4:2 = CPU level, bits 7:5 = engine level. With auto-assign off, a write is read back unchanged on `rd_data` after the write cycle.
- R3: With the gating enable at 0, every pending line appears on `req_out` whatever the two levels are.
- R4: With the gating enable at 1 and the CPU level strictly greater than the engine level, `req_out` is all zeros and the pending flags are retained.
- R5: With the gating enable at 1 and the CPU level equal to or below the engine level, pending lines are forwarded.
- R6: A held line is forwarded without a new request pulse once the gating enable is cleared or the levels change so that the CPU no longer outranks the engine.
- R7: With auto-assign on and `mode_sel` = 0 (single-bit mode), the CPU level reads as {`mask_bit`, 0, 0} and gating uses that value.
- R8: With auto-assign on and `mode_sel` = 1 (three-bit mode), the CPU level reads as `mask_lvl` and gating uses that value.
- R9: While auto-assign is on, a write does not change the CPU level; the other fields are still written.
- R10: A pulse on `req_in[i]` sets pending line i. A pulse on `req_ack[i]` clears it. When both arrive in the same cycle, the line stays pending.
- R11: When auto-assign is switched off, the CPU level keeps the last value derived from the mask, and later mask changes no longer affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value (CPU level shown as currently in effect) |
| mode_sel | input | 1 | Interrupt control mode: 0 single-bit, 1 three-bit |
| mask_bit | input | 1 | CPU mask bit used in single-bit mode |
| mask_lvl | input | 3 | CPU mask level used in three-bit mode |
| req_in | input | N_REQ | Activation request pulses |
| req_ack | input | N_REQ | Engine acknowledge pulses, one per line |
| req_out | output | N_REQ | Gated pending requests to the engine |

## Verification
The assertions assume that `req_ack` is only pulsed for a line the engine was offered. They also assume that the mask inputs and `mode_sel` change only between clock edges. The bench drives every input on the falling edge. It acknowledges only lines that are currently forwarded, except for the single deliberate case where a request and an acknowledge for the same line arrive in the same cycle.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
   localparam int LVL_W  = 3;
   localparam int CTRL_W = 2 + 2 * LVL_W;

   typedef struct packed {
      logic [LVL_W-1:0] eng_lvl;
      logic [LVL_W-1:0] cpu_lvl;
      logic             auto_en;
      logic             gate_en;
   } ctrl_t;
endpackage

// File: rtl/xpg_ctrl_reg.sv
module xpg_ctrl_reg
   import xpg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              mode_sel,
   input  logic              mask_bit,
   input  logic [LVL_W-1:0]  mask_lvl,
   output ctrl_t             ctrl_eff
);
   ctrl_t            ctrl_q;
   ctrl_t            wr_fields;
   logic [LVL_W-1:0] derived_lvl;

   assign wr_fields = ctrl_t'(wr_data);

   generate
      if (LVL_W > 1) begin : g_wide
         always_comb derived_lvl = mode_sel ? mask_lvl : {mask_bit, {(LVL_W-1){1'b0}}};
      end else begin : g_narrow
         always_comb derived_lvl = mode_sel ? mask_lvl : mask_bit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_en) begin
            ctrl_q.gate_en <= wr_fields.gate_en;
            ctrl_q.auto_en <= wr_fields.auto_en;
            ctrl_q.eng_lvl <= wr_fields.eng_lvl;
         end
         if (ctrl_q.auto_en)
            ctrl_q.cpu_lvl <= derived_lvl;
         else if (wr_en)
            ctrl_q.cpu_lvl <= wr_fields.cpu_lvl;
      end
   end

   always_comb begin
      ctrl_eff = ctrl_q;
      if (ctrl_q.auto_en)
         ctrl_eff.cpu_lvl = derived_lvl;
   end

   // R9
   wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctrl_q.auto_en) |=> (ctrl_q.cpu_lvl == $past(derived_lvl)));
   // R8
   mode_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.auto_en && mode_sel) |-> (ctrl_eff.cpu_lvl == mask_lvl));
   // R11
   auto_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.auto_en && !wr_en) |=> $stable(ctrl_q.cpu_lvl));
endmodule

// File: rtl/xpg_prio_cmp.sv
module xpg_prio_cmp
   import xpg_pkg::*;
(
   input  ctrl_t ctrl,
   output logic  hold
);
   always_comb hold = ctrl.gate_en && (ctrl.cpu_lvl > ctrl.eng_lvl);
endmodule

// File: rtl/xpg_pend_lane.sv
module xpg_pend_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ack,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (req)
         pend <= 1'b1;
      else if (ack)
         pend <= 1'b0;
   end

   // R10
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !ack) |=> pend);
   // R10
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req) |=> !pend);
endmodule

// File: rtl/xfer_prio_gate.sv
module xfer_prio_gate
   import xpg_pkg::*;
#(
   parameter int N_REQ = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   input  logic              mode_sel,
   input  logic              mask_bit,
   input  logic [LVL_W-1:0]  mask_lvl,
   input  logic [N_REQ-1:0]  req_in,
   input  logic [N_REQ-1:0]  req_ack,
   output logic [N_REQ-1:0]  req_out
);
   generate
      if (N_REQ < 1) begin : g_bad_n
         $error("xfer_prio_gate: N_REQ must be at least 1");
      end
      if (LVL_W < 1) begin : g_bad_w
         $error("xfer_prio_gate: LVL_W must be at least 1");
      end
   endgenerate

   ctrl_t            ctrl_eff;
   logic             hold;
   logic [N_REQ-1:0] pend;

   xpg_ctrl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .mode_sel (mode_sel),
      .mask_bit (mask_bit),
      .mask_lvl (mask_lvl),
      .ctrl_eff (ctrl_eff)
   );

   xpg_prio_cmp u_cmp (
      .ctrl (ctrl_eff),
      .hold (hold)
   );

   generate
      for (genvar i = 0; i < N_REQ; i++) begin : g_lane
         xpg_pend_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_in[i]),
            .ack   (req_ack[i]),
            .pend  (pend[i])
         );
      end
   endgenerate

   assign rd_data = CTRL_W'(ctrl_eff);
   assign req_out = hold ? '0 : pend;

   // R4
   held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[0] && (rd_data[4:2] > rd_data[7:5])) |-> (req_out == '0));
   // R3
   open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[0] |-> (req_out == pend));
endmodule

// File: tb/xfer_prio_gate_tb.sv
module xfer_prio_gate_tb;
   localparam int N = 4;
   localparam logic [N-1:0] ALL = '1;

   logic clk = 0;
   logic rst_n = 0;
   logic wr_en = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] rd_data;
   logic mode_sel = 0, mask_bit = 0;
   logic [2:0] mask_lvl = 0;
   logic [N-1:0] req_in = 0, req_ack = 0, req_out;

   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   xfer_prio_gate #(.N_REQ(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .mode_sel(mode_sel), .mask_bit(mask_bit), .mask_lvl(mask_lvl),
      .req_in(req_in), .req_ack(req_ack), .req_out(req_out)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      wr_en = 1; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 0;
      #1;
   endtask

   task automatic pulse(logic [N-1:0] r, logic [N-1:0] a);
      req_in = r; req_ack = a;
      @(posedge clk); @(negedge clk);
      req_in = 0; req_ack = 0;
      #1;
   endtask

   function automatic logic [7:0] cfg(int e, int c, int au, int g);
      return {3'(e), 3'(c), 1'(au), 1'(g)};
   endfunction

   initial begin
      fork
         begin
            repeat (50000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
         end
         begin
            repeat (3) @(posedge clk);
            @(negedge clk); rst_n = 1; #1;
            chk("R1 rd", rd_data, 0);
            chk("R1 out", req_out, 0);

            pulse(ALL, 0);
            chk("R10 set", req_out, ALL);

            for (int g = 0; g < 2; g++)
               for (int c = 0; c < 8; c++)
                  for (int e = 0; e < 8; e++) begin
                     wr(cfg(e, c, 0, g));
                     chk("R2 readback", rd_data, cfg(e, c, 0, g));
                     if (g == 0) chk("R3 open", req_out, ALL);
                     else if (c > e) chk("R4 held", req_out, 0);
                     else chk("R5 fwd", req_out, ALL);
                  end

            wr(cfg(1, 5, 0, 1));
            chk("R4 held", req_out, 0);
            wr(cfg(1, 5, 0, 0));
            chk("R6 gate off", req_out, ALL);
            wr(cfg(1, 5, 0, 1));
            wr(cfg(1, 1, 0, 1));
            chk("R6 level change", req_out, ALL);

            pulse(0, 4'b0001);
            chk("R10 ack", req_out, 4'b1110);
            pulse(4'b0010, 4'b0010);
            chk("R10 req+ack", req_out, 4'b1110);
            pulse(4'b0001, 0);
            chk("R10 reset", req_out, ALL);

            mode_sel = 0;
            for (int mb = 0; mb < 2; mb++)
               for (int e = 0; e < 8; e++) begin
                  mask_bit = 1'(mb);
                  wr(cfg(e, 3, 1, 1));
                  chk("R7 lvl", rd_data[4:2], mb ? 3'd4 : 3'd0);
                  chk("R7 gate", req_out, ((mb ? 4 : 0) > e) ? 0 : ALL);
               end

            mode_sel = 1;
            for (int m = 0; m < 8; m++)
               for (int e = 0; e < 8; e++) begin
                  mask_lvl = 3'(m);
                  wr(cfg(e, 7 - m, 1, 1));
                  chk("R8 lvl", rd_data[4:2], m);
                  chk("R8 gate", req_out, (m > e) ? 0 : ALL);
               end

            mask_lvl = 2;
            wr(cfg(6, 7, 1, 1));
            chk("R9 cpu kept", rd_data, cfg(6, 2, 1, 1));

            mask_lvl = 5;
            @(posedge clk); @(negedge clk); #1;
            wr(cfg(2, 0, 0, 1));
            chk("R11 keep", rd_data, cfg(2, 5, 0, 1));
            mask_lvl = 0;
            @(posedge clk); @(negedge clk); #1;
            chk("R11 no track", rd_data[4:2], 5);
            chk("R11 held", req_out, 0);

            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule